// File: doc/BRIEF.md
# Ready-Warp Issue Scheduler

This block chooses, on every clock, which of a fixed pool of resident warps issues its next instruction. Each warp holds 32 thread slots and runs as one unit. A warp that issues a long-latency instruction stops being eligible. Such instructions are global memory loads, pipelined floating-point operations and branches. The warp stays out until every completion it waits for has come back. While a warp waits, the other ready warps keep the issue slot busy, so switching between warps never leaves an empty cycle. Ready warps take turns in round-robin order.

Each warp slot is a small state machine with three states. SLOT_IDLE means the warp is not resident. SLOT_READY means the warp may issue. SLOT_WAIT means the warp has completions outstanding. The named transitions are listed below.
- arrive: SLOT_IDLE to SLOT_READY, one cycle after residency is asserted.
- block: SLOT_READY to SLOT_WAIT, when the warp is granted with a long-latency class.
- drain: SLOT_WAIT to SLOT_WAIT, when a completion arrives and others remain.
- release: SLOT_WAIT to SLOT_READY, on the last completion.
- evict: any state to SLOT_IDLE, whenever residency is removed.

A separate combinational path turns a thread coordinate into a warp number and a lane number. A 2D coordinate is first linearised as x·dim_y + y. The path also reports whether the lane holds a real thread or only pads out the last warp.

Top module: `warp_sched`

## Requirements
- R1: While reset is held and in the cycle after it is released, issue_valid is 0.
- R2: If any resident warp is in SLOT_READY in cycle t, issue_valid is 1 in cycle t+1, naming a warp granted at t.
- R3: Among eligible warps, the grant goes to the first one found scanning upward, with wrap-around, from the warp after the one last issued. After reset the scan starts at warp 0.
- R4: Class codes 1 (global memory), 2 (floating point) and 3 (branch) move the issued warp to SLOT_WAIT. Code 0 (short) leaves it in SLOT_READY.
- R5: A blocking instruction loads the warp's pending count from its next_count field, with 0 taken as 1. The warp returns to SLOT_READY only after that many done_pulse cycles.
- R6: A done_pulse for a warp that is in SLOT_IDLE or SLOT_READY has no effect.
- R7: If no resident warp is in SLOT_READY in cycle t, issue_valid is 0 in cycle t+1.
- R8: A warp whose warp_resident bit is 0 is never granted. Clearing the bit discards its pending count, and when the bit is set again the warp becomes ready one cycle later.
- R9: In 1D mode (map_2d = 0), the linear index is map_x, map_warp = index / 32 and map_lane = index mod 32.
- R10: In 2D mode, the linear index is map_x·map_dim_y + map_y, so an 8x8 block spans warps 0 and 1.
- R11: map_lane_live is 1 only when the coordinate lies inside the block dimensions. map_warp_count is the thread total divided by 32, rounded up.
- R12: issue_class reports the class code of the instruction issued with issue_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_resident | input | NUM_WARPS | Per-warp residency |
| next_class | input | 2·NUM_WARPS | Class code of each warp's next instruction, 2 bits per warp |
| next_count | input | CNT_W·NUM_WARPS | Completions the next instruction will produce, per warp |
| done_pulse | input | NUM_WARPS | One-cycle completion pulse per warp |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_warp | output | log2(NUM_WARPS) | Warp that issues |
| issue_class | output | 2 | Class code of the issued instruction |
| map_2d | input | 1 | Selects 2D linearisation |
| map_x | input | IDX_W | Thread x coordinate (flat index in 1D mode) |
| map_y | input | IDX_W | Thread y coordinate |
| map_dim_x | input | IDX_W | Block size in x |
| map_dim_y | input | IDX_W | Block size in y |
| map_warp | output | 2·IDX_W−5 | Warp number of the thread |
| map_lane | output | 5 | Lane within the warp |
| map_lane_live | output | 1 | Lane holds a real thread |
| map_warp_count | output | 2·IDX_W−4 | Warps needed by the block |

## Verification
A slot state or pending count that is wrong shows up at the issue port within one or two cycles. A warp that should be waiting appears as an issue_warp value too early. A counter that is wrong keeps a warp missing from the rotation after its last completion. An arbiter pointer that is wrong shows up on the very next issue as an out-of-order warp number. So every issue cycle is compared against a cycle-accurate prediction. Completion pulses go to blocked, ready and evicted warps alike. The mapper's outputs are checked at the edges of the padded last warp.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

    typedef enum logic [1:0] {
        LAT_ALU    = 2'd0,
        LAT_GMEM   = 2'd1,
        LAT_FPU    = 2'd2,
        LAT_BRANCH = 2'd3
    } lat_class_e;

    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_READY = 2'd1,
        SLOT_WAIT  = 2'd2
    } slot_state_e;

    function automatic logic is_long(input lat_class_e c);
        return c != LAT_ALU;
    endfunction

endpackage

// File: rtl/warp_slot.sv
module warp_slot
    import warp_sched_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             resident,
    input  logic             grant,
    input  lat_class_e       cls,
    input  logic [CNT_W-1:0] count,
    input  logic             done,
    output logic             ready
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    slot_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state decode: arrive, block, drain, release, evict
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!resident) begin
            state_d = SLOT_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                SLOT_IDLE: begin
                    state_d = SLOT_READY;
                    cnt_d   = '0;
                end
                SLOT_READY: begin
                    if (grant && is_long(cls)) begin
                        state_d = SLOT_WAIT;
                        cnt_d   = (count == '0) ? ONE : count;
                    end
                end
                SLOT_WAIT: begin
                    if (done) begin
                        if (cnt_q == ONE) begin
                            state_d = SLOT_READY;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                end
                default: begin
                    state_d = SLOT_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        ready = (state_q == SLOT_READY);
    end

    AST_WAIT_HAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SLOT_WAIT |-> cnt_q != '0); // R5

    AST_LAST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_WAIT && cnt_q == ONE && done && resident) |=> state_q == SLOT_READY); // R5

    AST_GRANT_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (state_q == SLOT_READY && resident)); // R8

    AST_EVICT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !resident |=> (state_q == SLOT_IDLE && cnt_q == '0)); // R8

endmodule

// File: rtl/warp_rr_arbiter.sv
module warp_rr_arbiter #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] last,
    output logic             gnt_valid,
    output logic [IDX_W-1:0] gnt_idx
);

    // scan from last+1 upward with wrap; first requester wins
    always_comb begin
        int pos;
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        pos       = 0;
        for (int k = 1; k <= N; k++) begin
            pos = (int'(last) + k) % N;
            if (!gnt_valid && req[IDX_W'(pos)]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IDX_W'(pos);
            end
        end
    end

endmodule

// File: rtl/thread_lane_map.sv
module thread_lane_map #(
    parameter int IDX_W = 10,
    parameter int LANES = 32,
    localparam int LANE_W = $clog2(LANES),
    localparam int LIN_W  = 2 * IDX_W,
    localparam int WARP_W = LIN_W - LANE_W
) (
    input  logic              mode_2d,
    input  logic [IDX_W-1:0]  x,
    input  logic [IDX_W-1:0]  y,
    input  logic [IDX_W-1:0]  dim_x,
    input  logic [IDX_W-1:0]  dim_y,
    output logic [WARP_W-1:0] warp,
    output logic [LANE_W-1:0] lane,
    output logic              live,
    output logic [WARP_W:0]   warp_count
);

    logic [LIN_W-1:0] linear;
    logic [LIN_W-1:0] total;
    logic [LIN_W:0]   rounded;

    always_comb begin
        if (mode_2d) begin
            linear = LIN_W'(x) * LIN_W'(dim_y) + LIN_W'(y);
            total  = LIN_W'(dim_x) * LIN_W'(dim_y);
            live   = (x < dim_x) && (y < dim_y);
        end else begin
            linear = LIN_W'(x);
            total  = LIN_W'(dim_x);
            live   = (x < dim_x);
        end
        rounded    = (LIN_W + 1)'(total) + (LIN_W + 1)'(LANES - 1);
        warp       = linear[LIN_W-1:LANE_W];
        lane       = linear[LANE_W-1:0];
        warp_count = rounded[LIN_W:LANE_W];
    end

endmodule

// File: rtl/warp_sched.sv
module warp_sched
    import warp_sched_pkg::*;
#(
    parameter int NUM_WARPS = 8,
    parameter int CNT_W     = 3,
    parameter int IDX_W     = 10,
    parameter int LANES     = 32,
    localparam int WID_W  = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int LANE_W = $clog2(LANES),
    localparam int LIN_W  = 2 * IDX_W,
    localparam int WARP_W = LIN_W - LANE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_WARPS-1:0]       warp_resident,
    input  logic [2*NUM_WARPS-1:0]     next_class,
    input  logic [CNT_W*NUM_WARPS-1:0] next_count,
    input  logic [NUM_WARPS-1:0]       done_pulse,
    output logic                       issue_valid,
    output logic [WID_W-1:0]           issue_warp,
    output logic [1:0]                 issue_class,
    input  logic                       map_2d,
    input  logic [IDX_W-1:0]           map_x,
    input  logic [IDX_W-1:0]           map_y,
    input  logic [IDX_W-1:0]           map_dim_x,
    input  logic [IDX_W-1:0]           map_dim_y,
    output logic [WARP_W-1:0]          map_warp,
    output logic [LANE_W-1:0]          map_lane,
    output logic                       map_lane_live,
    output logic [WARP_W:0]            map_warp_count
);

    logic [NUM_WARPS-1:0] ready_vec;
    logic [NUM_WARPS-1:0] eligible;
    logic                 pick_valid;
    logic [WID_W-1:0]     pick_idx;
    logic [WID_W-1:0]     last_q;
    logic [1:0]           pick_class;

    generate
        for (genvar g = 0; g < NUM_WARPS; g++) begin : g_slot
            warp_slot #(.CNT_W(CNT_W)) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .resident(warp_resident[g]),
                .grant   (pick_valid && (pick_idx == WID_W'(g))),
                .cls     (lat_class_e'(next_class[2*g +: 2])),
                .count   (next_count[CNT_W*g +: CNT_W]),
                .done    (done_pulse[g]),
                .ready   (ready_vec[g])
            );
        end
    endgenerate

    assign eligible = ready_vec & warp_resident;

    warp_rr_arbiter #(.N(NUM_WARPS), .IDX_W(WID_W)) u_arb (
        .req      (eligible),
        .last     (last_q),
        .gnt_valid(pick_valid),
        .gnt_idx  (pick_idx)
    );

    always_comb begin
        pick_class = next_class[2*pick_idx +: 2];
    end

    // issue register and rotation pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_valid <= 1'b0;
            issue_warp  <= '0;
            issue_class <= 2'd0;
            last_q      <= WID_W'(NUM_WARPS - 1);
        end else begin
            issue_valid <= pick_valid;
            if (pick_valid) begin
                issue_warp  <= pick_idx;
                issue_class <= pick_class;
                last_q      <= pick_idx;
            end
        end
    end

    thread_lane_map #(.IDX_W(IDX_W), .LANES(LANES)) u_map (
        .mode_2d   (map_2d),
        .x         (map_x),
        .y         (map_y),
        .dim_x     (map_dim_x),
        .dim_y     (map_dim_y),
        .warp      (map_warp),
        .lane      (map_lane),
        .live      (map_lane_live),
        .warp_count(map_warp_count)
    );

    AST_NO_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (|eligible) |=> issue_valid); // R2

    AST_EMPTY_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        !(|eligible) |=> !issue_valid); // R7

    AST_LONG_BLOCKS_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_class != LAT_ALU) |=> !(issue_valid && issue_warp == $past(issue_warp))); // R4

    AST_ISSUED_WAS_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (|($past(warp_resident) & (NUM_WARPS'(1) << issue_warp)))); // R8

endmodule

// File: tb/warp_sched_test.sv
module warp_sched_test;

    localparam int N      = 8;
    localparam int CNT_W  = 3;
    localparam int IDX_W  = 10;

    logic               clk;
    logic               rst_n;
    logic [N-1:0]       warp_resident;
    logic [2*N-1:0]     next_class;
    logic [CNT_W*N-1:0] next_count;
    logic [N-1:0]       done_pulse;
    logic               issue_valid;
    logic [2:0]         issue_warp;
    logic [1:0]         issue_class;
    logic               map_2d;
    logic [IDX_W-1:0]   map_x, map_y, map_dim_x, map_dim_y;
    logic [14:0]        map_warp;
    logic [4:0]         map_lane;
    logic               map_lane_live;
    logic [15:0]        map_warp_count;

    int checks = 0;
    int errors = 0;

    // reference model state: 0 idle, 1 ready, 2 waiting
    int mst  [N];
    int mcnt [N];
    int mlast;

    logic [5:0] exp_q [$];
    string      tag_q [$];
    string      cur_tag;
    logic [5:0] e;
    string      t;

    warp_sched uut (
        .clk(clk), .rst_n(rst_n), .warp_resident(warp_resident),
        .next_class(next_class), .next_count(next_count), .done_pulse(done_pulse),
        .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_class(issue_class),
        .map_2d(map_2d), .map_x(map_x), .map_y(map_y),
        .map_dim_x(map_dim_x), .map_dim_y(map_dim_y),
        .map_warp(map_warp), .map_lane(map_lane),
        .map_lane_live(map_lane_live), .map_warp_count(map_warp_count)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // monitor: compare each issue cycle against the predicted item
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (issue_valid !== e[5] ||
                (e[5] && (issue_warp !== e[4:2] || issue_class !== e[1:0]))) begin
                errors++;
                $display("FAIL %s: actual v=%0b w=%0d c=%0d expected v=%0b w=%0d c=%0d",
                         t, issue_valid, issue_warp, issue_class, e[5], e[4:2], e[1:0]);
            end
        end
    end

    task automatic set_cls(input int w, input logic [1:0] c, input int n);
        next_class[2*w +: 2]         = c;
        next_count[CNT_W*w +: CNT_W] = CNT_W'(n);
    endtask

    // driver: predict the edge, push the expectation, advance one cycle
    task automatic step(input logic [N-1:0] d);
        int pick;
        logic [1:0] c;
        int ld;
        done_pulse = d;
        pick = -1;
        for (int k = 1; k <= N; k++) begin
            int p;
            p = (mlast + k) % N;
            if (pick < 0 && mst[p] == 1 && warp_resident[p]) pick = p;
        end
        c = (pick >= 0) ? next_class[2*pick +: 2] : 2'd0;
        exp_q.push_back({pick >= 0, (pick >= 0) ? 3'(pick) : 3'd0, c});
        tag_q.push_back(cur_tag);
        for (int w = 0; w < N; w++) begin
            if (!warp_resident[w]) begin
                mst[w] = 0; mcnt[w] = 0;
            end else if (mst[w] == 0) begin
                mst[w] = 1;
            end else if (mst[w] == 1) begin
                if (w == pick && c != 2'd0) begin
                    ld = int'(next_count[CNT_W*w +: CNT_W]);
                    mst[w] = 2; mcnt[w] = (ld == 0) ? 1 : ld;
                end
            end else if (d[w]) begin
                if (mcnt[w] == 1) begin mst[w] = 1; mcnt[w] = 0; end
                else mcnt[w] = mcnt[w] - 1;
            end
        end
        if (pick >= 0) mlast = pick;
        @(negedge clk);
        done_pulse = '0;
    endtask

    task automatic chk_map(input logic m, input int x, input int y, input int dx, input int dy,
                           input int ew, input int el, input logic elive, input int ecnt,
                           input string tag);
        map_2d = m; map_x = IDX_W'(x); map_y = IDX_W'(y);
        map_dim_x = IDX_W'(dx); map_dim_y = IDX_W'(dy);
        #1;
        checks++;
        if (map_warp !== 15'(ew) || map_lane !== 5'(el) || map_lane_live !== elive ||
            map_warp_count !== 16'(ecnt)) begin
            errors++;
            $display("FAIL %s: actual w=%0d l=%0d live=%0b cnt=%0d expected w=%0d l=%0d live=%0b cnt=%0d",
                     tag, map_warp, map_lane, map_lane_live, map_warp_count, ew, el, elive, ecnt);
        end
    endtask

    initial begin
        rst_n = 1'b0; warp_resident = '0; next_class = '0; next_count = '0;
        done_pulse = '0; map_2d = 1'b0; map_x = '0; map_y = '0;
        map_dim_x = '0; map_dim_y = '0;
        for (int w = 0; w < N; w++) begin mst[w] = 0; mcnt[w] = 0; end
        mlast = N - 1;
        cur_tag = "R1";
        repeat (3) @(negedge clk);
        checks++;
        if (issue_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: actual v=%0b expected v=0", issue_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (issue_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: actual v=%0b expected v=0 after release", issue_valid);
        end

        // R7: nothing resident, nothing issues
        cur_tag = "R7";
        repeat (3) step('0);

        // R2, R3: all resident, short instructions, rotation from warp 0
        cur_tag = "R2,R3";
        warp_resident = '1;
        repeat (20) step('0);

        // R4, R12: each blocking class removes its warp from rotation
        cur_tag = "R4,R12";
        set_cls(2, 2'd1, 1); set_cls(5, 2'd2, 1); set_cls(6, 2'd3, 1);
        repeat (12) step('0);
        set_cls(2, 2'd0, 0); set_cls(5, 2'd0, 0); set_cls(6, 2'd0, 0);
        step(8'b0110_0100);
        repeat (10) step('0);

        // R5: three completions are needed before warp 3 returns
        cur_tag = "R5";
        set_cls(3, 2'd1, 3);
        for (int i = 0; i < 12 && mst[3] != 2; i++) step('0);
        set_cls(3, 2'd0, 0);
        step(8'b0000_1000); repeat (3) step('0);
        step(8'b0000_1000); repeat (3) step('0);
        step(8'b0000_1000); repeat (10) step('0);
        // R5: a count of zero behaves as one
        set_cls(4, 2'd2, 0);
        for (int i = 0; i < 12 && mst[4] != 2; i++) step('0);
        set_cls(4, 2'd0, 0);
        repeat (2) step('0);
        step(8'b0001_0000);
        repeat (10) step('0);

        // R6: completions to ready warps change nothing
        cur_tag = "R6";
        step('1); step('1); step(8'b1010_1010);
        repeat (10) step('0);

        // R7: single resident warp blocked, issue slot stays empty
        cur_tag = "R7";
        warp_resident = 8'b0000_0010;
        set_cls(1, 2'd1, 2);
        for (int i = 0; i < 6 && mst[1] != 2; i++) step('0);
        set_cls(1, 2'd0, 0);
        repeat (4) step('0);
        step(8'b0000_0010); repeat (2) step('0);
        step(8'b0000_0010); repeat (4) step('0);

        // R8: eviction discards pending completions; partial residency
        cur_tag = "R8";
        warp_resident = '1;
        repeat (2) step('0);
        set_cls(0, 2'd1, 4);
        for (int i = 0; i < 12 && mst[0] != 2; i++) step('0);
        set_cls(0, 2'd0, 0);
        repeat (2) step('0);
        warp_resident = 8'b1111_1110;
        step('0);
        warp_resident = '1;
        repeat (12) step('0);
        warp_resident = 8'b1010_0101;
        repeat (12) step('0);

        // drain scoreboard
        repeat (3) @(negedge clk);

        // R9: flat indexing, 40 threads
        chk_map(1'b0, 0, 0, 40, 1, 0, 0, 1'b1, 2, "R9");
        chk_map(1'b0, 37, 0, 40, 1, 1, 5, 1'b1, 2, "R9");
        chk_map(1'b0, 31, 0, 40, 1, 0, 31, 1'b1, 2, "R9");
        // R11: padded lane of the last warp, warp-count rounding
        chk_map(1'b0, 45, 0, 40, 1, 1, 13, 1'b0, 2, "R11");
        chk_map(1'b0, 10, 0, 64, 1, 0, 10, 1'b1, 2, "R11");
        chk_map(1'b0, 64, 0, 65, 1, 2, 0, 1'b1, 3, "R11");
        // R10: 8x8 block, x major
        chk_map(1'b1, 0, 0, 8, 8, 0, 0, 1'b1, 2, "R10");
        chk_map(1'b1, 3, 7, 8, 8, 0, 31, 1'b1, 2, "R10");
        chk_map(1'b1, 4, 0, 8, 8, 1, 0, 1'b1, 2, "R10");
        chk_map(1'b1, 7, 7, 8, 8, 1, 31, 1'b1, 2, "R10");
        // R11: 5x7 block of 35 threads
        chk_map(1'b1, 4, 6, 5, 7, 1, 2, 1'b1, 2, "R11");
        chk_map(1'b1, 5, 0, 5, 7, 1, 3, 1'b0, 2, "R11");
        chk_map(1'b1, 2, 7, 5, 7, 0, 21, 1'b0, 2, "R11");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule